// File: doc/BRIEF.md
# Shift and Rotate Unit

This block carries out the bit-moving operations of an integer execution stage. It handles arithmetic shifts, logical shifts, plain rotates and rotates that pass through the extend flag, in either direction. Operands can be byte, word or long. It also exchanges the two 16-bit halves of a long. The shift count comes from a 3-bit instruction field or from the low six bits of a register. A separate one-place memory form always works on a word.

The unit is iterative and moves one bit position per clock. A `start` pulse is accepted while the unit is idle. `busy` stays high while the operation runs. `done` pulses for one cycle when the result and the five flags are loaded into the output registers. Those outputs then hold their values until the next completion. Only the bits inside the selected operand size are changed. The bits above them pass through to `result` unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: `op` selects the operation: 000 arithmetic shift, 001 logical shift, 010 rotate, 011 rotate through X, and any code with bit 2 set is half swap. `dir_left`=1 means left. `size` 00 is byte (bits 7:0), 01 is word (bits 15:0), and 10 or 11 is long. Result bits above the operand size equal the operand bits.
- R2: With `cnt_from_reg`=0 the count is `cnt_imm`, and code 000 means 8. With `cnt_from_reg`=1 the count is `cnt_reg` (0 to 63).
- R3: A `start` seen while `busy`=0 is accepted. `done` is a one-cycle pulse N clock edges after the accepting edge, where N is the count, or 1 when the count is 0. `busy` is high from the accepting edge up to the `done` edge. A `start` seen while busy is ignored.
- R4: For shifts, C and X both take the last bit shifted out. Counts at or above the operand width give the bit-serial result: logical shifts and left arithmetic shifts give 0, and a right arithmetic shift fills with the sign.
- R5: V is set only by a left arithmetic shift in which the most significant bit of the operand size changes at any step. Every other operation clears V.
- R6: A plain rotate leaves X unchanged. C is the last bit rotated out, which ends in the least significant bit for left and in the most significant bit for right. A word rotated by 8 has its two bytes exchanged.
- R7: A rotate through X rotates the (size+1)-bit value {X, operand}. X and C both take the bit that ends up in the X position.
- R8: A zero count leaves the operand unchanged, clears C and V, and leaves X unchanged.
- R9: N is the most significant bit of the result within the size. Z is 1 when the result bits within the size are all zero.
- R10: The swap returns {operand[15:0], operand[31:16]} after 1 cycle. It treats the value as long for N and Z, clears C and V, and keeps X.
- R11: `mem_mode`=1 forces a word operand and a count of 1, whatever `size`, `cnt_from_reg`, `cnt_imm` and `cnt_reg` hold.
- R12: After reset, `busy`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 3 | Operation code |
| dir_left | input | 1 | 1 = left, 0 = right |
| size | input | 2 | Operand size |
| cnt_from_reg | input | 1 | 1 = count from register, 0 = from field |
| cnt_imm | input | 3 | Count field, 000 means 8 |
| cnt_reg | input | 6 | Register count, modulo 64 |
| mem_mode | input | 1 | One-place word form |
| operand | input | 32 | Source operand |
| x_in | input | 1 | Current extend flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result value |
| x_out | output | 1 | Updated extend flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |

## Verification
The hardest cases to reach are those where the count runs past the operand width. Examples are a rotate through X by exactly size+1, a right arithmetic shift of a negative byte by 20 to 63, and a left arithmetic shift whose sign changes only in its last step. A random draw seldom lands on them, so the bench drives these register counts directly. It also aims a second `start` at the middle of a long operation, to show that the pulse is ignored. A reference model then checks `busy` and `done` on every clock, and the result and flags at each completion, across a few hundred random operations.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [2:0] {
    OP_ASH = 3'd0,
    OP_LSH = 3'd1,
    OP_ROT = 3'd2,
    OP_ROX = 3'd3,
    OP_SWP = 3'd4
  } sru_op_e;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
endpackage

// File: rtl/sru_count_sel.sv
module sru_count_sel #(
  parameter int IMM_W = 3,
  parameter int CNT_W = 6
) (
  input  logic             is_swap,
  input  logic             mem_mode,
  input  logic             from_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] IMM_ZERO_MEANS = CNT_W'(1 << IMM_W);

  always_comb begin
    if (is_swap)            cnt = '0;
    else if (mem_mode)      cnt = CNT_W'(1);
    else if (from_reg)      cnt = reg_cnt;
    else if (imm == '0)     cnt = IMM_ZERO_MEANS;
    else                    cnt = CNT_W'(imm);
  end
endmodule

// File: rtl/sru_bit_step.sv
module sru_bit_step
  import sru_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  input  logic [IDX_W-1:0]  msb_idx,
  input  sru_op_e           op,
  input  logic              left,
  input  logic              x_in,
  output logic [DATA_W-1:0] nd,
  output logic              out_bit,
  output logic              x_nxt,
  output logic              sign_flip
);
  logic              top_bit;
  logic              fill_l;
  logic              fill_r;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] shr;

  always_comb begin
    top_bit = d[msb_idx];
    fill_l  = 1'b0;
    fill_r  = 1'b0;
    case (op)
      OP_ASH:  fill_r = top_bit;
      OP_ROT:  begin fill_l = top_bit; fill_r = d[0]; end
      OP_ROX:  begin fill_l = x_in;    fill_r = x_in; end
      default: ;
    endcase
    shl = {d[DATA_W-2:0], fill_l};
    shr = {1'b0, d[DATA_W-1:1]};
    for (int i = 0; i < DATA_W; i++) begin
      if (i > int'(msb_idx))       nd[i] = d[i];
      else if (left)               nd[i] = shl[i];
      else if (i == int'(msb_idx)) nd[i] = fill_r;
      else                         nd[i] = shr[i];
    end
    out_bit   = left ? top_bit : d[0];
    x_nxt     = (op == OP_ROT || op == OP_SWP) ? x_in : out_bit;
    sign_flip = (op == OP_ASH) && left && (nd[msb_idx] != top_bit);
  end
endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  input  logic [IDX_W-1:0]  msb_idx,
  output logic              neg,
  output logic              zero
);
  logic [DATA_W-1:0] in_size;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      in_size[i] = (i <= int'(msb_idx));
    neg  = d[msb_idx];
    zero = ~|(d & in_size);
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 3,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              dir_left,
  input  logic [1:0]        size,
  input  logic              cnt_from_reg,
  input  logic [IMM_W-1:0]  cnt_imm,
  input  logic [CNT_W-1:0]  cnt_reg,
  input  logic              mem_mode,
  input  logic [DATA_W-1:0] operand,
  input  logic              x_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              x_out,
  output logic              n_out,
  output logic              z_out,
  output logic              v_out,
  output logic              c_out
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [IDX_W-1:0] MSB_B = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] MSB_W = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] MSB_L = IDX_W'(DATA_W - 1);

  // decode
  sru_op_e          op_dec;
  logic [IDX_W-1:0] msb_dec;
  logic [CNT_W-1:0] cnt_eff;

  assign op_dec = op[2] ? OP_SWP : sru_op_e'({1'b0, op[1:0]});

  always_comb begin
    if (op_dec == OP_SWP)  msb_dec = MSB_L;
    else if (mem_mode)     msb_dec = MSB_W;
    else if (size == 2'd0) msb_dec = MSB_B;
    else if (size == 2'd1) msb_dec = MSB_W;
    else                   msb_dec = MSB_L;
  end

  sru_count_sel #(.IMM_W(IMM_W), .CNT_W(CNT_W)) u_cnt (
    .is_swap (op_dec == OP_SWP),
    .mem_mode(mem_mode),
    .from_reg(cnt_from_reg),
    .imm     (cnt_imm),
    .reg_cnt (cnt_reg),
    .cnt     (cnt_eff)
  );

  // working state
  logic              busy_q, done_q;
  logic [DATA_W-1:0] work_q;
  logic              xe_q, xl_q, c_q, v_q, zc_q;
  logic [CNT_W-1:0]  remain_q;
  sru_op_e           op_q;
  logic              left_q;
  logic [IDX_W-1:0]  msb_q;

  logic [DATA_W-1:0] step_d;
  logic              step_out, step_x, step_flip;

  sru_bit_step #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_step (
    .d        (work_q),
    .msb_idx  (msb_q),
    .op       (op_q),
    .left     (left_q),
    .x_in     (xe_q),
    .nd       (step_d),
    .out_bit  (step_out),
    .x_nxt    (step_x),
    .sign_flip(step_flip)
  );

  logic              stepping;
  logic [DATA_W-1:0] fin_d;
  logic              fin_x, fin_c, fin_v, fin_n, fin_z;

  assign stepping = (remain_q != '0);
  assign fin_d    = stepping ? step_d   : work_q;
  assign fin_x    = stepping ? step_x   : xe_q;
  assign fin_c    = stepping ? step_out : c_q;
  assign fin_v    = v_q | (stepping & step_flip);

  sru_flag_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_flags (
    .d      (fin_d),
    .msb_idx(msb_q),
    .neg    (fin_n),
    .zero   (fin_z)
  );

  // registered outputs
  logic [DATA_W-1:0] result_q;
  logic              x_out_q, n_out_q, z_out_q, v_out_q, c_out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      work_q   <= '0;
      xe_q     <= 1'b0;
      xl_q     <= 1'b0;
      c_q      <= 1'b0;
      v_q      <= 1'b0;
      zc_q     <= 1'b0;
      remain_q <= '0;
      op_q     <= OP_ASH;
      left_q   <= 1'b0;
      msb_q    <= MSB_L;
      result_q <= '0;
      x_out_q  <= 1'b0;
      n_out_q  <= 1'b0;
      z_out_q  <= 1'b0;
      v_out_q  <= 1'b0;
      c_out_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          work_q   <= (op_dec == OP_SWP) ?
                      {operand[HALF_W-1:0], operand[DATA_W-1:HALF_W]} : operand;
          xe_q     <= x_in;
          xl_q     <= x_in;
          c_q      <= 1'b0;
          v_q      <= 1'b0;
          zc_q     <= (cnt_eff == '0);
          remain_q <= cnt_eff;
          op_q     <= op_dec;
          left_q   <= dir_left;
          msb_q    <= msb_dec;
        end
      end else begin
        if (stepping) begin
          work_q   <= step_d;
          xe_q     <= step_x;
          c_q      <= step_out;
          v_q      <= fin_v;
          remain_q <= remain_q - CNT_W'(1);
        end
        if (remain_q <= CNT_W'(1)) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= fin_d;
          x_out_q  <= fin_x;
          n_out_q  <= fin_n;
          z_out_q  <= fin_z;
          v_out_q  <= fin_v;
          c_out_q  <= fin_c;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = result_q;
  assign x_out  = x_out_q;
  assign n_out  = n_out_q;
  assign z_out  = z_out_q;
  assign v_out  = v_out_q;
  assign c_out  = c_out_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R3
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q);
  // R3
  idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R5
  v_only_asl_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && v_out_q) |-> (op_q == OP_ASH && left_q));
  // R6
  rot_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && (op_q == OP_ROT || op_q == OP_SWP)) |-> (x_out_q == xl_q));
  // R6
  rot_popcount_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && op_q == OP_ROT && stepping) |=>
      ($countones(work_q) == $past($countones(work_q))));
  // R8
  zero_cnt_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && zc_q) |-> (!c_out_q && !v_out_q && x_out_q == xl_q));
endmodule

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic        dir_left;
  logic [1:0]  size;
  logic        cnt_from_reg;
  logic [2:0]  cnt_imm;
  logic [5:0]  cnt_reg;
  logic        mem_mode;
  logic [31:0] operand;
  logic        x_in;
  logic        busy, done, x_out, n_out, z_out, v_out, c_out;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shift_rotate_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .dir_left(dir_left),
    .size(size), .cnt_from_reg(cnt_from_reg), .cnt_imm(cnt_imm),
    .cnt_reg(cnt_reg), .mem_mode(mem_mode), .operand(operand), .x_in(x_in),
    .busy(busy), .done(done), .result(result), .x_out(x_out),
    .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  task automatic ref_model(input int opc, input bit lft, input int sz,
                           input bit mem, input bit fr, input int imm,
                           input int regc, input logic [31:0] d, input bit xi,
                           output logic [31:0] r, output bit xo, output bit no,
                           output bit zo, output bit vo, output bit co,
                           output int lat);
    int w, cnt, rr, w1;
    logic [127:0] big, tmp, e, m1;
    logic [31:0] mask, val, res;
    bit swap, b;
    swap = (opc >= 4);
    if (swap)      cnt = 0;
    else if (mem)  cnt = 1;
    else if (fr)   cnt = regc % 64;
    else           cnt = (imm == 0) ? 8 : imm;
    w = swap ? 32 : mem ? 16 : (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    val = d & mask;
    res = val; xo = xi; co = 0; vo = 0;
    lat = (cnt == 0) ? 1 : cnt;
    if (swap) res = {d[15:0], d[31:16]};
    else if (cnt != 0) begin
      case (opc)
        0, 1: begin
          if (lft) begin
            big = 128'(val) << cnt;
            res = big[31:0] & mask;
            co = big[w];
            if (opc == 0)
              for (int k = 0; k <= cnt; k++) begin
                b = (w - 1 - k >= 0) ? val[w-1-k] : 1'b0;
                if (b != val[w-1]) vo = 1;
              end
          end else begin
            big = 128'(val);
            if (opc == 0 && val[w-1]) big = big | ~(128'(mask));
            co = big[cnt-1];
            tmp = big >> cnt;
            res = tmp[31:0] & mask;
          end
          xo = co;
        end
        2: begin
          rr = cnt % w;
          if (!lft) rr = (w - rr) % w;
          big = 128'(val) << rr;
          tmp = big >> w;
          res = (big[31:0] | tmp[31:0]) & mask;
          co = lft ? res[0] : res[w-1];
        end
        default: begin
          w1 = w + 1;
          e = 128'(val) | (128'(xi) << w);
          rr = cnt % w1;
          if (!lft) rr = (w1 - rr) % w1;
          m1 = (128'(1) << w1) - 128'(1);
          big = e << rr;
          tmp = (big | (big >> w1)) & m1;
          res = tmp[31:0] & mask;
          xo = tmp[w];
          co = xo;
        end
      endcase
    end
    no = res[w-1];
    zo = ((res & mask) == 32'd0);
    r = swap ? res : ((d & ~mask) | res);
  endtask

  task automatic run_op(string tag, int opc, bit lft, int sz, bit mem, bit fr,
                        int imm, int regc, logic [31:0] d, bit xi, bit poke);
    logic [31:0] er;
    bit ex, en, ez, ev, ec;
    int lat;
    ref_model(opc, lft, sz, mem, fr, imm, regc, d, xi, er, ex, en, ez, ev, ec, lat);
    op = 3'(opc); dir_left = lft; size = 2'(sz); mem_mode = mem;
    cnt_from_reg = fr; cnt_imm = 3'(imm); cnt_reg = 6'(regc);
    operand = d; x_in = xi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= lat; i++) begin
      if (poke && i == 1) begin
        start = 1'b1; operand = ~d; x_in = ~xi; op = 3'd1;
      end
      @(negedge clk);
      start = 1'b0;
      chk(tag, "done", 32'(done), 32'(i == lat));
      chk(tag, "busy", 32'(busy), 32'(i < lat));
      if (i == lat) begin
        chk(tag, "result", result, er);
        chk(tag, "X", 32'(x_out), 32'(ex));
        chk(tag, "N", 32'(n_out), 32'(en));
        chk(tag, "Z", 32'(z_out), 32'(ez));
        chk(tag, "V", 32'(v_out), 32'(ev));
        chk(tag, "C", 32'(c_out), 32'(ec));
      end
    end
    @(negedge clk);
    chk(tag, "done low after pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; op = 3'd0; dir_left = 1'b0; size = 2'd0;
    cnt_from_reg = 1'b0; cnt_imm = 3'd0; cnt_reg = 6'd0; mem_mode = 1'b0;
    operand = 32'd0; x_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "busy", 32'(busy), 0);
    chk("R12", "done", 32'(done), 0);
    chk("R12", "result", result, 0);
    chk("R12", "flags", {27'd0, x_out, n_out, z_out, v_out, c_out}, 0);

    // R1 upper bits untouched for byte size
    run_op("R1", 1, 1, 0, 0, 0, 1, 0, 32'hA5A5_A5F0, 0, 0);
    chk("R1", "upper bits", result & 32'hFFFF_FF00, 32'hA5A5_A500);
    // R2 immediate 000 means 8
    run_op("R2", 1, 1, 1, 0, 0, 0, 0, 32'h0000_00FF, 0, 0);
    chk("R2", "imm 000 = 8", result, 32'h0000_FF00);
    // R2 register count modulo 64 (67 -> 3)
    run_op("R2", 1, 0, 2, 0, 1, 0, 67, 32'h0000_0080, 0, 0);
    chk("R2", "reg count mod 64", result, 32'h0000_0010);
    // R4 large counts
    run_op("R4", 1, 0, 2, 0, 1, 0, 40, 32'hFFFF_FFFF, 1, 0);
    chk("R4", "lsr long by 40", result, 32'd0);
    run_op("R4", 0, 0, 0, 0, 1, 0, 20, 32'h1234_5680, 0, 0);
    chk("R4", "asr byte sign fill", result, 32'h1234_56FF);
    run_op("R4", 1, 1, 0, 0, 1, 0, 8, 32'h0000_0001, 0, 0);
    // R5 overflow
    run_op("R5", 0, 1, 0, 0, 0, 1, 0, 32'h0000_0040, 0, 0);
    chk("R5", "V on sign change", 32'(v_out), 1);
    run_op("R5", 0, 1, 0, 0, 0, 1, 0, 32'h0000_00C0, 0, 0);
    chk("R5", "no V when sign kept", 32'(v_out), 0);
    run_op("R5", 0, 1, 1, 0, 1, 0, 15, 32'h0000_0001, 0, 0);
    // R6 word rotate by 8 swaps bytes
    run_op("R6", 2, 1, 1, 0, 0, 0, 0, 32'hABCD_1234, 1, 0);
    chk("R6", "byte swap", result, 32'hABCD_3412);
    run_op("R6", 2, 0, 2, 0, 1, 0, 33, 32'h0000_0003, 0, 0);
    // R7 rotate through X by width+1 returns the operand
    run_op("R7", 3, 1, 0, 0, 1, 0, 9, 32'h0000_005A, 1, 0);
    chk("R7", "full cycle", result, 32'h0000_005A);
    run_op("R7", 3, 0, 1, 0, 0, 3, 0, 32'h0000_8001, 1, 0);
    // R8 zero counts
    run_op("R8", 0, 1, 2, 0, 1, 0, 0, 32'h8000_0001, 1, 0);
    run_op("R8", 3, 0, 0, 0, 1, 0, 0, 32'h0000_0001, 1, 0);
    // R9 N and Z
    run_op("R9", 1, 1, 2, 0, 0, 1, 0, 32'h8000_0000, 0, 0);
    chk("R9", "Z on zero", 32'(z_out), 1);
    run_op("R9", 1, 0, 1, 0, 0, 1, 0, 32'hFFFF_0000, 0, 0);
    chk("R9", "Z within word", 32'(z_out), 1);
    // R10 swap
    run_op("R10", 4, 0, 0, 0, 1, 0, 17, 32'h1234_ABCD, 1, 0);
    chk("R10", "halves", result, 32'hABCD_1234);
    // R11 memory form
    run_op("R11", 1, 1, 0, 1, 0, 5, 0, 32'h0000_8181, 0, 0);
    chk("R11", "word by one", result, 32'h0000_0302);
    // R3 start during busy ignored
    run_op("R3", 2, 1, 2, 0, 1, 0, 12, 32'h0F0F_1234, 0, 1);
    run_op("R3", 1, 0, 1, 0, 0, 1, 0, 32'h0000_0002, 0, 1);

    for (int n = 0; n < 300; n++) begin
      int opc;
      string tg;
      opc = $urandom_range(0, 4);
      tg = (opc == 0) ? "R5" : (opc == 1) ? "R4" : (opc == 2) ? "R6" :
           (opc == 3) ? "R7" : "R10";
      run_op(tg, opc, 1'($urandom_range(0, 1)), $urandom_range(0, 3),
             (opc != 4) && ($urandom_range(0, 9) == 0),
             1'($urandom_range(0, 1)), $urandom_range(0, 7),
             $urandom_range(0, 63), $urandom, 1'($urandom_range(0, 1)), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule